// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This unit maps a two-part logical address to a physical address. The two parts are a segment number and an offset within that segment. A table of per-segment descriptors holds the mapping. Each descriptor has a physical start address, a segment length, a validity flag and three access privileges: read, write and execute. A length register sets how many segments are usable, counted from segment zero.

For each request the unit runs three independent checks. The segment number must be below the table length. The offset must fall inside the segment. The access kind must be permitted. Each check has its own fault code. When all checks pass, the physical address is the descriptor's start address plus the offset. The result is registered, so it appears one cycle after the request with a valid strobe.

Software loads descriptors and the length register through a configuration write port before it issues requests.

Top module: `seg_xlate_unit`

## Requirements
- R1: A synchronous active-high reset clears `rsp_valid`, sets the table length to 0 and marks every descriptor invalid. Base, limit and permission fields are not reset.
- R2: A request whose segment number is greater than or equal to the table length gets fault code 1. This check wins over all other checks.
- R3: A request to a segment below the table length whose descriptor is invalid gets fault code 2.
- R4: A request to a valid segment whose offset is greater than or equal to the segment limit gets fault code 3. An offset of limit-1 passes this check.
- R5: The access kind is encoded as 0 = read, 1 = write and 2 = execute. These kinds need descriptor permission bit 0, bit 1 and bit 2 respectively. A request that passes the R2-style range, validity and limit checks but lacks the needed permission gets fault code 4. Access kind 3 is never permitted.
- R6: A request that passes every check gets fault code 0. Its physical address is the base plus the zero-extended offset, modulo 2^32.
- R7: When a request faults, `rsp_paddr` is 0.
- R8: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. The fault code and address shown in that cycle belong to that request.
- R9: A descriptor write is used by requests in later cycles. A request in the same cycle as the write sees the old descriptor.
- R10: A write to the length register sets the table length used by requests in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write enable |
| cfg_idx | input | 4 | Descriptor index to write |
| cfg_base | input | 32 | Segment base (physical start address) |
| cfg_limit | input | 20 | Segment length |
| cfg_valid | input | 1 | Descriptor validity flag |
| cfg_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| len_we | input | 1 | Table length register write enable |
| len_val | input | 5 | New table length (0 to 16) |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | 4 | Segment number |
| req_ofs | input | 20 | Offset within segment |
| req_type | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Result strobe, one cycle after request |
| rsp_fault | output | 3 | 0 ok, 1 segment range, 2 invalid, 3 limit, 4 permission |
| rsp_paddr | output | 32 | Physical address (0 on fault) |

## Verification
A corrupted descriptor shows up at the ports on the first request to that segment, one cycle later. It appears as a wrong address, as a limit fault at the wrong offset, or as a wrong permission verdict. A wrong length register or a lost validity flag turns successful translations into fault code 1 or 2 on the next request. A wrong fault priority shows only when several checks fail at once, so the stimulus deliberately combines failures. The boundary offsets limit-1 and limit show whether the limit comparison is off by one.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_SEGNUM  = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_LIMIT   = 3'd3,
    FLT_PERM    = 3'd4
  } fault_e;

  localparam int unsigned ACC_W  = 2;
  localparam int unsigned PERM_W = 3;

  localparam logic [ACC_W-1:0] ACC_READ  = 2'd0;
  localparam logic [ACC_W-1:0] ACC_WRITE = 2'd1;
  localparam logic [ACC_W-1:0] ACC_EXEC  = 2'd2;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
  parameter int unsigned NSEG   = 16,
  parameter int unsigned BASE_W = 32,
  parameter int unsigned LIM_W  = 20,
  localparam int unsigned SEG_W = $clog2(NSEG)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [SEG_W-1:0]                    wr_idx,
  input  logic [BASE_W-1:0]                   wr_base,
  input  logic [LIM_W-1:0]                    wr_limit,
  input  logic                                wr_valid,
  input  logic [seg_xlate_pkg::PERM_W-1:0]    wr_perm,
  input  logic [SEG_W-1:0]                    rd_idx,
  output logic [BASE_W-1:0]                   rd_base,
  output logic [LIM_W-1:0]                    rd_limit,
  output logic                                rd_valid,
  output logic [seg_xlate_pkg::PERM_W-1:0]    rd_perm
);
  import seg_xlate_pkg::*;

  // Field storage without reset so it maps onto distributed RAM.
  logic [BASE_W-1:0] base_mem [NSEG];
  logic [LIM_W-1:0]  lim_mem  [NSEG];
  logic [PERM_W-1:0] perm_mem [NSEG];
  logic [NSEG-1:0]   valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      base_mem[wr_idx] <= wr_base;
      lim_mem[wr_idx]  <= wr_limit;
      perm_mem[wr_idx] <= wr_perm;
    end
  end

  // Validity flags are reset, one flop per entry.
  for (genvar g = 0; g < NSEG; g++) begin : g_valid
    always_ff @(posedge clk) begin
      if (rst)
        valid_q[g] <= 1'b0;
      else if (wr_en && (wr_idx == SEG_W'(g)))
        valid_q[g] <= wr_valid;
    end
  end

  assign rd_base  = base_mem[rd_idx];
  assign rd_limit = lim_mem[rd_idx];
  assign rd_perm  = perm_mem[rd_idx];
  assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int unsigned SEG_W  = 4,
  parameter int unsigned BASE_W = 32,
  parameter int unsigned LIM_W  = 20
) (
  input  logic [SEG_W-1:0]                 seg,
  input  logic [LIM_W-1:0]                 ofs,
  input  logic [seg_xlate_pkg::ACC_W-1:0]  acc,
  input  logic [SEG_W:0]                   tbl_len,
  input  logic [BASE_W-1:0]                d_base,
  input  logic [LIM_W-1:0]                 d_limit,
  input  logic                             d_valid,
  input  logic [seg_xlate_pkg::PERM_W-1:0] d_perm,
  output seg_xlate_pkg::fault_e            fault,
  output logic [BASE_W-1:0]                paddr
);
  import seg_xlate_pkg::*;

  logic perm_ok;

  always_comb begin
    unique case (acc)
      ACC_READ:  perm_ok = d_perm[0];
      ACC_WRITE: perm_ok = d_perm[1];
      ACC_EXEC:  perm_ok = d_perm[2];
      default:   perm_ok = 1'b0;
    endcase
  end

  // Priority: range, validity, limit, permission.
  always_comb begin
    if ({1'b0, seg} >= tbl_len)
      fault = FLT_SEGNUM;
    else if (!d_valid)
      fault = FLT_INVALID;
    else if (ofs >= d_limit)
      fault = FLT_LIMIT;
    else if (!perm_ok)
      fault = FLT_PERM;
    else
      fault = FLT_NONE;
  end

  assign paddr = (fault == FLT_NONE) ? (d_base + BASE_W'(ofs)) : '0;
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int unsigned NSEG   = 16,
  parameter int unsigned BASE_W = 32,
  parameter int unsigned LIM_W  = 20,
  localparam int unsigned SEG_W = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEG_W-1:0]  cfg_idx,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [LIM_W-1:0]  cfg_limit,
  input  logic              cfg_valid,
  input  logic [2:0]        cfg_perm,
  input  logic              len_we,
  input  logic [SEG_W:0]    len_val,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [LIM_W-1:0]  req_ofs,
  input  logic [1:0]        req_type,
  output logic              rsp_valid,
  output logic [2:0]        rsp_fault,
  output logic [BASE_W-1:0] rsp_paddr
);
  import seg_xlate_pkg::*;

  logic [SEG_W:0]    len_q;
  logic [BASE_W-1:0] d_base;
  logic [LIM_W-1:0]  d_limit;
  logic              d_valid;
  logic [PERM_W-1:0] d_perm;
  fault_e            fault_c;
  logic [BASE_W-1:0] paddr_c;

  always_ff @(posedge clk) begin
    if (rst)         len_q <= '0;
    else if (len_we) len_q <= len_val;
  end

  seg_desc_table #(.NSEG(NSEG), .BASE_W(BASE_W), .LIM_W(LIM_W)) tbl_i (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_base(cfg_base),
    .wr_limit(cfg_limit), .wr_valid(cfg_valid), .wr_perm(cfg_perm),
    .rd_idx(req_seg), .rd_base(d_base), .rd_limit(d_limit),
    .rd_valid(d_valid), .rd_perm(d_perm)
  );

  seg_check #(.SEG_W(SEG_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) chk_logic_i (
    .seg(req_seg), .ofs(req_ofs), .acc(req_type), .tbl_len(len_q),
    .d_base(d_base), .d_limit(d_limit), .d_valid(d_valid), .d_perm(d_perm),
    .fault(fault_c), .paddr(paddr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= fault_c;
        rsp_paddr <= paddr_c;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned SEG_W  = 4,
  parameter int unsigned BASE_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [SEG_W-1:0]  req_seg,
  input logic [1:0]        req_type,
  input logic [SEG_W:0]    len_q,
  input logic              rsp_valid,
  input logic [2:0]        rsp_fault,
  input logic [BASE_W-1:0] rsp_paddr
);
  // R8: result strobe follows request strobe by one cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r8_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R2: out-of-range segment gives code 1
  a_r2_seg_range: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ({1'b0, req_seg} >= len_q)) |=> (rsp_fault == 3'd1));
  // R5: access kind 3 never succeeds
  a_r5_reserved_kind: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_type == 2'd3) |=> (rsp_fault != 3'd0));
  // R7: faulting results carry a zero address
  a_r7_fault_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == '0));
  // R2 to R6: code stays within the defined set
  a_r6_code_range: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault <= 3'd4));
endmodule

bind seg_xlate_unit seg_xlate_chk #(.SEG_W(SEG_W), .BASE_W(BASE_W)) sva_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_seg(req_seg),
  .req_type(req_type), .len_q(len_q), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/seg_xlate_unit_tb.sv
module seg_xlate_unit_tb_top;
  localparam int NSEG = 16;
  localparam int SEG_W = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [31:0] cfg_base;
  logic [19:0] cfg_limit;
  logic        cfg_valid;
  logic [2:0]  cfg_perm;
  logic        len_we;
  logic [4:0]  len_val;
  logic        req_valid;
  logic [3:0]  req_seg;
  logic [19:0] req_ofs;
  logic [1:0]  req_type;
  logic        rsp_valid;
  logic [2:0]  rsp_fault;
  logic [31:0] rsp_paddr;

  int tests = 0;
  int fails = 0;

  logic [31:0] m_base [NSEG];
  logic [19:0] m_lim  [NSEG];
  logic [2:0]  m_perm [NSEG];
  logic        m_val  [NSEG];
  int          m_len;

  always #2.5 clk = ~clk;

  seg_xlate_unit dut_i (.*);

  function automatic logic [2:0] exp_fault(int s, logic [19:0] o, logic [1:0] t);
    if (s >= m_len) return 3'd1;
    if (!m_val[s]) return 3'd2;
    if (o >= m_lim[s]) return 3'd3;
    if (t == 2'd3 || !m_perm[s][t]) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [31:0] exp_addr(int s, logic [19:0] o, logic [1:0] t);
    if (exp_fault(s, o, t) != 3'd0) return 32'd0;
    return m_base[s] + {12'd0, o};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_desc(int i, logic [31:0] b, logic [19:0] l, logic v, logic [2:0] p);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'(i); cfg_base = b; cfg_limit = l; cfg_valid = v; cfg_perm = p;
    @(negedge clk);
    cfg_we = 0;
    m_base[i] = b; m_lim[i] = l; m_val[i] = v; m_perm[i] = p;
  endtask

  task automatic wr_len(int n);
    @(negedge clk);
    len_we = 1; len_val = 5'(n);
    @(negedge clk);
    len_we = 0;
    m_len = n;
  endtask

  // Issue one request, then check the result one cycle later.
  task automatic xlate(string req, int s, logic [19:0] o, logic [1:0] t);
    @(negedge clk);
    req_valid = 1; req_seg = 4'(s); req_ofs = o; req_type = t;
    @(negedge clk);
    req_valid = 0;
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " fault"}, 32'(rsp_fault), 32'(exp_fault(s, o, t)));
    check({req, " paddr"}, rsp_paddr, exp_addr(s, o, t));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EC7));
    rst = 1; cfg_we = 0; cfg_idx = 0; cfg_base = 0; cfg_limit = 0; cfg_valid = 0;
    cfg_perm = 0; len_we = 0; len_val = 0; req_valid = 0; req_seg = 0; req_ofs = 0; req_type = 0;
    m_len = 0;
    for (int i = 0; i < NSEG; i++) begin
      m_base[i] = 0; m_lim[i] = 0; m_perm[i] = 0; m_val[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    xlate("R1 len zero after reset", 0, 20'd0, 2'd0);
    @(negedge clk);
    check("R8 idle after request", 32'(rsp_valid), 32'd0);

    wr_len(16);
    xlate("R1 entry invalid after reset", 3, 20'd5, 2'd0);

    // Directed corner cases
    wr_desc(2, 32'h1000_0000, 20'h00100, 1, 3'b001);
    xlate("R4 offset limit-1", 2, 20'h000FF, 2'd0);
    xlate("R4 offset equal limit", 2, 20'h00100, 2'd0);
    xlate("R5 write not permitted", 2, 20'h00010, 2'd1);
    xlate("R5 exec not permitted", 2, 20'h00010, 2'd2);
    xlate("R5 kind 3 never allowed", 2, 20'h00010, 2'd3);
    xlate("R7 limit beats perm", 2, 20'h00200, 2'd2);
    wr_desc(4, 32'hFFFF_FF00, 20'hFFFFF, 1, 3'b111);
    xlate("R6 address wraps", 4, 20'h00200, 2'd2);
    wr_desc(6, 32'h0, 20'h00010, 0, 3'b111);
    xlate("R3 invalid beats limit", 6, 20'h00020, 2'd0);
    wr_len(5);
    xlate("R10 shorter length", 6, 20'h00001, 2'd0);
    xlate("R2 range beats invalid", 5, 20'h0, 2'd0);
    xlate("R10 below length ok", 4, 20'h00001, 2'd1);

    // R9: write and request in the same cycle sees old descriptor
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4; cfg_base = 32'h0000_4000; cfg_limit = 20'h00050;
    cfg_valid = 1; cfg_perm = 3'b010;
    req_valid = 1; req_seg = 4; req_ofs = 20'h00060; req_type = 2'd0;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    check("R9 same-cycle fault", 32'(rsp_fault), 32'd0);
    check("R9 same-cycle paddr", rsp_paddr, 32'hFFFF_FF00 + 32'h60);
    m_base[4] = 32'h0000_4000; m_lim[4] = 20'h00050; m_perm[4] = 3'b010;
    xlate("R9 later sees new limit", 4, 20'h00060, 2'd1);
    xlate("R9 later sees new base", 4, 20'h00010, 2'd1);

    // Random mix
    wr_len(16);
    for (int i = 0; i < NSEG; i++)
      wr_desc(i, $urandom, 20'($urandom_range(1, 20'hFFFFF)), 1'($urandom_range(0, 3) != 0),
              3'($urandom));
    wr_len(int'($urandom_range(8, 16)));
    for (int n = 0; n < 300; n++) begin
      int s;
      logic [19:0] o;
      s = int'($urandom_range(0, 15));
      case ($urandom_range(0, 3))
        0: o = m_lim[s] - 20'd1;
        1: o = m_lim[s];
        default: o = 20'($urandom);
      endcase
      xlate("R6 random", s, o, 2'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule